// File: doc/BRIEF.md
# Linked-List Descriptor Sequencer

A per-channel engine that runs a chain of transfer descriptors held in memory. Software places a chain of eight-word descriptors in memory, writes the address of the first node into the channel's head register, and then sets the list-enable bit in the channel's control register. The engine reads each descriptor one word at a time over a simple word-read memory port. Once all eight words are in, it starts a data mover with the source address, destination address and byte count taken from the descriptor. When the mover reports completion, the engine follows the descriptor's next-node pointer.

A next pointer of zero ends the chain. A pointer back to an earlier node turns the chain into an endless loop, which is how cyclic transfers are built. Setting the cancel bit stops the channel at any point. The remaining-size register counts down the bytes left in the current descriptor. It holds the count minus one, so all ones means both "nothing left" and "a full 2^24 bytes". Two event pulses mark the first descriptor loaded and each transfer completed.

Top module: `ll_desc_seq`

## Requirements
- R1: A descriptor is eight 32-bit words at node, node+4, … node+28. The engine reads them in ascending order, with one read outstanding at a time. The word roles are: word 2 is the source address, word 3 is the destination address, bits 23:0 of word 4 are the byte count minus one, and word 5 is the next-node address. The contents of words 0, 1, 6 and 7 have no effect on the transfer.
- R2: The engine starts the mover only after the eighth word has returned. The xfer_start_o signal is a one-cycle pulse, with the source, destination and length-minus-one of that descriptor on the parameter outputs.
- R3: If the next-node word is zero, the chain ends after that descriptor's transfer completes. No further memory reads or mover starts follow.
- R4: If the next-node word is nonzero, the engine fetches that node next. A pointer back to an earlier node repeats the chain in order without end.
- R5: The head register sits at window offset 0x00. Writing bit 4 of the control register (offset 0x04) while the channel is idle starts a walk from the head address. The head register reads back the value written.
- R6: Writing bit 20 of the control register stops the channel. No further descriptor read or mover start occurs until the channel is enabled again, and the remaining size reads all ones.
- R7: The remaining-size register at offset 0x08 reads all ones after reset. It loads the length-minus-one when a transfer starts and drops by BEAT_BYTES on each mover beat. It reads all ones once the transfer completes.
- R8: A descriptor whose 24-bit length field is all ones reads as all ones in the remaining-size register after its transfer completes. This is the same value shown when no bytes are left.
- R9: The channel answers only to register addresses whose bits above 5 equal CHAN_IDX (window base CHAN_IDX×0x40). Writes to other windows have no effect.
- R10: loaded_evt_o pulses once per walk, when the first descriptor has loaded. done_evt_o pulses once for each completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RA_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_rd_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | AW | Descriptor word byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| xfer_start_o | output | 1 | Mover start pulse |
| xfer_src_o | output | AW | Transfer source address |
| xfer_dst_o | output | AW | Transfer destination address |
| xfer_len_m1_o | output | LEN_W | Transfer byte count minus one |
| xfer_beat_i | input | 1 | Mover moved BEAT_BYTES bytes |
| xfer_done_i | input | 1 | Mover finished the transfer |
| loaded_evt_o | output | 1 | First descriptor of a walk loaded |
| done_evt_o | output | 1 | A transfer completed |

## Verification
The in-line assertions cover the local timing rules on every cycle. They check that a read request is never followed directly by another, that a start only comes right after a returned word, that a start is a single-cycle pulse, and that a cancel silences the read and start outputs at once. They also check that the remaining size steps by one beat and goes to all ones on completion. Whole-chain behaviour can only be shown by the bench's scenarios: descriptor order across a linked list, termination on a zero pointer, the endless loop of a cyclic chain, the ambiguity of an all-ones length, and register-window decoding.

// File: rtl/ll_seq_pkg.sv
package ll_seq_pkg;
  localparam int unsigned DESC_WORDS  = 8;
  localparam int unsigned W_SRC       = 2;
  localparam int unsigned W_DST       = 3;
  localparam int unsigned W_SIZE      = 4;
  localparam int unsigned W_NEXT      = 5;
  localparam int unsigned BIT_LIST_EN = 4;
  localparam int unsigned BIT_CANCEL  = 20;
  localparam int unsigned WIN_LSB     = 6;  // 0x40-byte window per channel
  localparam logic [WIN_LSB-1:0] OFS_HEAD = 6'h00;
  localparam logic [WIN_LSB-1:0] OFS_CTRL = 6'h04;
  localparam logic [WIN_LSB-1:0] OFS_REM  = 6'h08;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_START, ST_BUSY
  } walk_st_e;
endpackage

// File: rtl/ll_seq_regs.sv
module ll_seq_regs
  import ll_seq_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned RA_W     = 12,
  parameter int unsigned CHAN_IDX = 2,
  parameter int unsigned LEN_W    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             walk_busy_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [AW-1:0]    head_o,
  output logic             go_o,
  output logic             cancel_o
);
  localparam int unsigned SEL_W = RA_W - WIN_LSB;

  logic               sel;
  logic [WIN_LSB-1:0] ofs;
  logic               ctrl_wr;
  logic [AW-1:0]      head_q;

  assign sel     = reg_addr_i[RA_W-1:WIN_LSB] == SEL_W'(CHAN_IDX);
  assign ofs     = reg_addr_i[WIN_LSB-1:0];
  assign ctrl_wr = reg_we_i && sel && (ofs == OFS_CTRL);
  assign cancel_o = ctrl_wr && reg_wdata_i[BIT_CANCEL];
  assign go_o     = ctrl_wr && reg_wdata_i[BIT_LIST_EN] && !reg_wdata_i[BIT_CANCEL]
                    && !walk_busy_i;
  assign head_o   = head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  head_q <= '0;
    else if (reg_we_i && sel && ofs == OFS_HEAD)  head_q <= AW'(reg_wdata_i);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel) begin
      if (ofs == OFS_HEAD)     reg_rdata_o = 32'(head_q);
      else if (ofs == OFS_REM) reg_rdata_o = 32'(rem_i);
    end
  end
endmodule

// File: rtl/ll_seq_walk.sv
module ll_seq_walk
  import ll_seq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             cancel_i,
  input  logic [AW-1:0]    head_i,
  output logic             mem_rd_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             xfer_start_o,
  output logic [AW-1:0]    xfer_src_o,
  output logic [AW-1:0]    xfer_dst_o,
  output logic [LEN_W-1:0] xfer_len_m1_o,
  input  logic             xfer_done_i,
  output logic             busy_o,
  output logic             loaded_evt_o,
  output logic             done_evt_o
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_SRC  = IDX_W'(W_SRC);
  localparam logic [IDX_W-1:0] IDX_DST  = IDX_W'(W_DST);
  localparam logic [IDX_W-1:0] IDX_SIZE = IDX_W'(W_SIZE);
  localparam logic [IDX_W-1:0] IDX_NEXT = IDX_W'(W_NEXT);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  walk_st_e         st_q;
  logic [AW-1:0]    node_q, src_q, dst_q, next_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx_q;
  logic             first_q;

  assign mem_rd_o      = st_q == ST_FETCH;
  assign mem_addr_o    = node_q + (AW'(idx_q) << 2);
  assign xfer_start_o  = st_q == ST_START;
  assign xfer_src_o    = src_q;
  assign xfer_dst_o    = dst_q;
  assign xfer_len_m1_o = len_q;
  assign busy_o        = st_q != ST_IDLE;
  assign loaded_evt_o  = xfer_start_o && first_q;
  assign done_evt_o    = (st_q == ST_BUSY) && xfer_done_i && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; node_q <= '0; idx_q <= '0; first_q <= 1'b0;
      src_q <= '0; dst_q <= '0; next_q <= '0; len_q <= '0;
    end else if (cancel_i) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          node_q <= head_i; idx_q <= '0; first_q <= 1'b1; st_q <= ST_FETCH;
        end
        ST_FETCH: st_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (idx_q == IDX_SRC)  src_q  <= AW'(mem_rdata_i);
          if (idx_q == IDX_DST)  dst_q  <= AW'(mem_rdata_i);
          if (idx_q == IDX_SIZE) len_q  <= mem_rdata_i[LEN_W-1:0];
          if (idx_q == IDX_NEXT) next_q <= AW'(mem_rdata_i);
          if (idx_q == IDX_LAST) st_q <= ST_START;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_FETCH;
          end
        end
        ST_START: begin
          first_q <= 1'b0;
          st_q    <= ST_BUSY;
        end
        ST_BUSY: if (xfer_done_i) begin
          if (next_q == '0) st_q <= ST_IDLE;
          else begin
            node_q <= next_q; idx_q <= '0; st_q <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  one_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  // R2
  start_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> $past(mem_rvalid_i));
  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  // R6
  cancel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (!mem_rd_o && !xfer_start_o));
  // R3
  chain_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt_o && next_q == '0) |=> !busy_o);
endmodule

// File: rtl/ll_seq_remain.sv
module ll_seq_remain #(
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned BEAT_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             beat_i,
  input  logic             busy_i,
  input  logic             cancel_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic [LEN_W-1:0] rem_o
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BEAT_BYTES);

  logic [LEN_W-1:0] rem_q;
  assign rem_o = rem_q;

  // count held minus one: all ones = nothing left (or a full 2^LEN_W)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rem_q <= '1;
    else if (cancel_i || done_i) rem_q <= '1;
    else if (start_i)           rem_q <= len_m1_i;
    else if (beat_i && busy_i)  rem_q <= rem_q - STEP;
  end

  // R7
  done_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rem_o == '1);
  // R7
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && busy_i && !start_i && !done_i && !cancel_i) |=>
      rem_o == $past(rem_o) - STEP);
endmodule

// File: rtl/ll_desc_seq.sv
module ll_desc_seq #(
  parameter int unsigned AW         = 32,
  parameter int unsigned RA_W       = 12,
  parameter int unsigned CHAN_IDX   = 2,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned BEAT_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             mem_rd_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             xfer_start_o,
  output logic [AW-1:0]    xfer_src_o,
  output logic [AW-1:0]    xfer_dst_o,
  output logic [LEN_W-1:0] xfer_len_m1_o,
  input  logic             xfer_beat_i,
  input  logic             xfer_done_i,
  output logic             loaded_evt_o,
  output logic             done_evt_o
);
  logic             go, cancel, busy;
  logic [AW-1:0]    head;
  logic [LEN_W-1:0] rem;

  ll_seq_regs #(.AW(AW), .RA_W(RA_W), .CHAN_IDX(CHAN_IDX), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .walk_busy_i(busy), .rem_i(rem), .head_o(head), .go_o(go), .cancel_o(cancel)
  );

  ll_seq_walk #(.AW(AW), .LEN_W(LEN_W)) u_walk (
    .clk_i, .rst_ni, .go_i(go), .cancel_i(cancel), .head_i(head),
    .mem_rd_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .xfer_start_o, .xfer_src_o, .xfer_dst_o, .xfer_len_m1_o, .xfer_done_i,
    .busy_o(busy), .loaded_evt_o, .done_evt_o
  );

  ll_seq_remain #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_remain (
    .clk_i, .rst_ni, .start_i(xfer_start_o), .done_i(done_evt_o),
    .beat_i(xfer_beat_i), .busy_i(busy), .cancel_i(cancel),
    .len_m1_i(xfer_len_m1_o), .rem_o(rem)
  );
endmodule

// File: tb/ll_desc_seq_tb.sv
`timescale 1ns/1ps
module ll_desc_seq_tb;
  localparam int unsigned CH   = 2;
  localparam logic [11:0] BASE = 12'(CH * 'h40);
  localparam logic [11:0] A_HEAD = BASE + 12'h00;
  localparam logic [11:0] A_CTRL = BASE + 12'h04;
  localparam logic [11:0] A_REM  = BASE + 12'h08;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [23:0] len;
  } xf_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = A_REM;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_rd, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        xs;
  logic [31:0] xsrc, xdst;
  logic [23:0] xlen;
  logic        beat = 1'b0, done = 1'b0;
  logic        lev, dev;

  int tests = 0, fails = 0;
  int rd_cnt = 0, loaded_n = 0, done_n = 0;
  logic [31:0] mem [64];
  xf_t exp_q [$];
  int  mv_beats = 0, mv_cnt = 0;
  logic mv_on = 1'b0, after_chk = 1'b0;
  logic [23:0] exp_rem = '0;

  always #10 clk = ~clk;

  ll_desc_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .xfer_start_o(xs), .xfer_src_o(xsrc),
    .xfer_dst_o(xdst), .xfer_len_m1_o(xlen), .xfer_beat_i(beat),
    .xfer_done_i(done), .loaded_evt_o(lev), .done_evt_o(dev)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0; reg_addr = A_REM; reg_wdata = '0;
  endtask

  // driver: lay out a node; push = expected on the scoreboard
  task automatic put_desc(int node, logic [31:0] s, logic [31:0] d,
                          logic [23:0] l, logic [31:0] nxt);
    for (int i = 0; i < 8; i++) mem[node/4 + i] = 32'hBAD0_0000 | 32'(i);
    mem[node/4 + 2] = s;
    mem[node/4 + 3] = d;
    mem[node/4 + 4] = {8'hEE, l};
    mem[node/4 + 5] = nxt;
  endtask

  task automatic push(logic [31:0] s, logic [31:0] d, logic [23:0] l);
    xf_t x;
    x.src = s; x.dst = d; x.len = l;
    exp_q.push_back(x);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // memory model: one cycle latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[7:2]];
      rd_cnt     <= rd_cnt + 1;
    end
  end

  // mover model
  always @(posedge clk) begin
    beat <= 1'b0;
    done <= 1'b0;
    if (xs) begin
      mv_on <= 1'b1; mv_cnt <= mv_beats;
    end else if (mv_on) begin
      if (mv_cnt > 0) begin beat <= 1'b1; mv_cnt <= mv_cnt - 1; end
      else begin done <= 1'b1; mv_on <= 1'b0; end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (lev) loaded_n++;
    if (dev) done_n++;
    if (after_chk) begin
      chk("R7 rem all ones after done", 32'(reg_rdata), 32'h00FF_FFFF);
      after_chk = 1'b0;
    end
    if (xs) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R3/R6 unexpected start actual=%h expected=none", xsrc);
      end else begin
        xf_t e;
        e = exp_q.pop_front();
        chk("R1/R2/R4 src", xsrc, e.src);
        chk("R1/R2/R4 dst", xdst, e.dst);
        chk("R1/R2 len_m1", 32'(xlen), 32'(e.len));
      end
      mv_beats = (xlen >= 24'h100) ? 2 : (int'(xlen) + 1) / 4;
      exp_rem  = xlen - 24'(4 * mv_beats);
    end
    if (done && reg_addr == A_REM) begin
      chk("R7 rem at done", 32'(reg_rdata), 32'(exp_rem));
      after_chk = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    int r0;
    foreach (mem[i]) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 rem reset", reg_rdata, 32'h00FF_FFFF);
    chk("R2 start idle at reset", 32'(xs), 32'h0);
    chk("R1 no read at reset", 32'(mem_rd), 32'h0);

    // T1: three-node chain, window decode
    put_desc('h00, 32'h1000, 32'h2000, 24'd15, 32'h20);
    put_desc('h20, 32'h1100, 32'h2100, 24'd7,  32'h40);
    put_desc('h40, 32'h1200, 32'h2200, 24'd31, 32'h0);
    push(32'h1000, 32'h2000, 24'd15);
    push(32'h1100, 32'h2100, 24'd7);
    push(32'h1200, 32'h2200, 24'd31);
    reg_wr(A_HEAD, 32'h0);
    reg_wr(12'h040, 32'hC0);            // R9: other channel window
    reg_wr(12'h0C4, 32'h1 << 4);        // R9: other channel list enable
    repeat (5) @(negedge clk);
    chk("R9 foreign enable ignored", 32'(rd_cnt), 32'd0);
    reg_wr(A_HEAD - 12'h40 + 12'h40, 32'h0);
    reg_addr = A_HEAD; #1;
    chk("R5/R9 head readback", reg_rdata, 32'h0);
    reg_addr = A_REM;
    reg_wr(A_CTRL, 32'h1 << 4);
    wait (done_n == 3);
    repeat (40) @(negedge clk);
    chk("R3 reads stop at zero next", 32'(rd_cnt), 32'd24);
    chk("R10 loaded once", 32'(loaded_n), 32'd1);
    chk("R10 done per transfer", 32'(done_n), 32'd3);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);

    // T2: cyclic chain, then cancel
    put_desc('h60, 32'h3000, 32'h4000, 24'd11, 32'h80);
    put_desc('h80, 32'h3100, 32'h4100, 24'd3,  32'h60);
    for (int k = 0; k < 2; k++) begin
      push(32'h3000, 32'h4000, 24'd11);
      push(32'h3100, 32'h4100, 24'd3);
    end
    push(32'h3000, 32'h4000, 24'd11);
    reg_wr(A_HEAD, 32'h60);
    reg_wr(A_CTRL, 32'h1 << 4);
    wait (done_n == 8);
    repeat (2) @(negedge clk);
    reg_wr(A_CTRL, 32'h1 << 20);
    repeat (4) @(negedge clk);
    r0 = rd_cnt;
    repeat (60) @(negedge clk);
    chk("R6 no read after cancel", 32'(rd_cnt), 32'(r0));
    chk("R4 loop order consumed", 32'(exp_q.size()), 32'd0);
    chk("R10 loaded once per walk", 32'(loaded_n), 32'd2);
    chk("R6 rem after cancel", reg_rdata, 32'h00FF_FFFF);

    // T3: all-ones length
    put_desc('hA0, 32'h5000, 32'h6000, 24'hFF_FFFF, 32'h0);
    push(32'h5000, 32'h6000, 24'hFF_FFFF);
    reg_wr(A_HEAD, 32'hA0);
    reg_wr(A_CTRL, 32'h1 << 4);
    wait (done_n == 9);
    repeat (3) @(negedge clk);
    chk("R8 full-size reads all ones when finished", reg_rdata, 32'h00FF_FFFF);

    // T4: cancel in the middle of a fetch
    put_desc('hC0, 32'h7000, 32'h8000, 24'd15, 32'hE0);
    r0 = rd_cnt;
    reg_wr(A_HEAD, 32'hC0);
    reg_wr(A_CTRL, 32'h1 << 4);
    wait (rd_cnt == r0 + 3);
    reg_wr(A_CTRL, (32'h1 << 20) | (32'h1 << 4));
    repeat (4) @(negedge clk);
    r0 = rd_cnt;
    repeat (40) @(negedge clk);
    chk("R6 fetch halted", 32'(rd_cnt), 32'(r0));
    chk("R6 no start after cancel", 32'(done_n), 32'd9);
    chk("R6 rem idle", reg_rdata, 32'h00FF_FFFF);
    report();
  end
endmodule